// File: doc/BRIEF.md
# Three-Wire Switch Register Access Master

This block lets on-chip logic read and write the configuration registers and statistics counters of an external Ethernet switch device over a slow three-wire serial link. The link has a select line, a serial clock and one data line shared by both directions. The user side presents a single request: read or write, a table select, an address and 16-bit write data. The block then runs the whole serial exchange by itself. When the exchange ends it raises `done` for one cycle, and for a read it returns the result on `rdata` in that same cycle.

Reads and writes use different framings. A read leaves the select line inactive. It sends a long run of one bits, then a short command, then releases the data line, gives two turnaround clocks and shifts in a 32-bit word. A write raises the select line around a 27-bit command that carries the address and data. Both kinds of exchange start with every line driven low and end with trailing clocks. All three drivers are then released. The length of each serial clock phase is a parameter that counts system clocks. The shared data line appears as separate output, output-enable and input signals.

Top module: `sreg_link_master`

## Requirements
- R1: After reset, `busy`, `done` and all three output enables are 0, and `rdata` is 0.
- R2: A read sends 46 bits MSB first while `link_sel` stays 0. The bits are 32 ones, then 0,1,1,0, then the table select, then 0,0, then address bits 6..0.
- R3: After the read command, `link_dout_oe` drops. Two clocks pass, then 32 bits are taken from `link_din` MSB first, each sampled at the end of a clock-low phase. Two trailing clocks follow. A read gives 82 rising clock edges in total, and `link_dout_oe` is 0 at every rising edge after the 46th.
- R4: For table select 0 the result is zero-extended 16 bits: bits 31..16 of the received word for an odd address, bits 15..0 for an even one. For table select 1 the whole 32-bit word is returned.
- R5: A write raises `link_sel` and sends 27 bits MSB first: 1, then 0,1, then the 8-bit address, then the 16-bit data. `link_sel` then falls before 2 trailing clocks. A write gives 29 rising edges, 27 of them with `link_sel` high.
- R6: While driven, `link_dout` changes only while `link_clk` is low. Each high and each low phase of `link_clk` lasts at least `HALF_CYC` system clocks.
- R7: In the first busy cycle all three enables are 1 and all three lines are 0. `link_sel` falls only while `link_clk` is low. In the cycle after `done`, all enables are 0.
- R8: `busy` stays high from the cycle after a request is accepted until `done`. That is 168·`HALF_CYC` cycles for a read and 62·`HALF_CYC` for a write. A request raised while busy is ignored and changes neither the running exchange nor the device.
- R9: `done` is a one-cycle pulse that falls together with `busy`, and `rdata` holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_table | input | 1 | Read table select: 0 = configuration, 1 = counters |
| req_addr | input | 8 | Register address (reads use bits 6..0) |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, valid with `done` |
| link_sel | output | 1 | Select line value |
| link_sel_oe | output | 1 | Select line driver enable |
| link_clk | output | 1 | Serial clock value |
| link_clk_oe | output | 1 | Serial clock driver enable |
| link_dout | output | 1 | Data line value driven by the master |
| link_dout_oe | output | 1 | Data line driver enable |
| link_din | input | 1 | Data line value seen by the master |

## Verification
A wrong sequencer state shows up within one clock phase at the link pins. It can appear as a rising-edge count other than 82 or 29, as the select line high during a read, or as the data driver still enabled when the device begins to answer. A behavioural device model on the bench decodes every frame, so a bad bit-counter or shift-register value shows up as a mangled header or address as soon as that exchange ends. Later reads then return wrong register contents. Errors in the result-select path or in the busy timing appear in the `done` cycle as a wrong `rdata` or a wrong busy length.

// File: rtl/sreg_link_pkg.sv
package sreg_link_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;
    localparam int WORD_W     = 32;
    localparam int PRE_W      = 32;
    localparam int RD_ADDR_W  = 7;
    localparam int RD_CMD_W   = 4 + 1 + 2 + RD_ADDR_W;
    localparam int RD_FRAME_W = PRE_W + RD_CMD_W;
    localparam int WR_FRAME_W = 1 + 2 + ADDR_W + DATA_W;
    localparam int FRAME_W    = (RD_FRAME_W > WR_FRAME_W) ? RD_FRAME_W : WR_FRAME_W;
    localparam int CNT_W      = $clog2(FRAME_W + 1);
    localparam int XTRA_CLKS  = 2;
    localparam int XC_W       = (XTRA_CLKS > 1) ? $clog2(XTRA_CLKS) : 1;

    localparam logic [3:0] RD_OPCODE = 4'b0110;
    localparam logic [2:0] WR_OPCODE = 3'b101;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENA,
        ST_CSUP,
        ST_CMD_LO,
        ST_CMD_HI,
        ST_CMD_END,
        ST_TURN,
        ST_XTR_HI,
        ST_XTR_LO,
        ST_RD_LO,
        ST_RD_HI,
        ST_RD_END
    } link_state_e;

    typedef struct packed {
        logic              write;
        logic              tbl;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } link_req_t;

    function automatic logic [FRAME_W-1:0] read_frame(link_req_t r);
        logic [RD_FRAME_W-1:0] f;
        f = {{PRE_W{1'b1}}, RD_OPCODE, r.tbl, 2'b00, r.addr[RD_ADDR_W-1:0]};
        return {f, {(FRAME_W - RD_FRAME_W){1'b0}}};
    endfunction

    function automatic logic [FRAME_W-1:0] write_frame(link_req_t r);
        logic [WR_FRAME_W-1:0] f;
        f = {WR_OPCODE, r.addr, r.wdata};
        return {f, {(FRAME_W - WR_FRAME_W){1'b0}}};
    endfunction

endpackage

// File: rtl/sreg_half_timer.sv
module sreg_half_timer #(
    parameter int HALF_CYC = 600
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

    generate
        if (HALF_CYC > 1) begin : g_spaced
            // R6: phase boundaries never come back to back
            a_r6_tick_spaced: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/sreg_frame_build.sv
module sreg_frame_build
    import sreg_link_pkg::*;
(
    input  link_req_t          req,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   nbits
);
    always_comb begin
        if (req.write) begin
            frame = write_frame(req);
            nbits = CNT_W'(WR_FRAME_W);
        end else begin
            frame = read_frame(req);
            nbits = CNT_W'(RD_FRAME_W);
        end
    end
endmodule

// File: rtl/sreg_word_pick.sv
module sreg_word_pick
    import sreg_link_pkg::*;
(
    input  logic              tbl,
    input  logic              odd,
    input  logic [WORD_W-1:0] raw,
    output logic [WORD_W-1:0] word
);
    localparam int HALF_W = WORD_W / 2;

    always_comb begin
        if (tbl) begin
            word = raw;
        end else if (odd) begin
            word = {{HALF_W{1'b0}}, raw[WORD_W-1:HALF_W]};
        end else begin
            word = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/sreg_link_master.sv
module sreg_link_master
    import sreg_link_pkg::*;
#(
    parameter int HALF_CYC = 600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_table,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic              link_sel,
    output logic              link_sel_oe,
    output logic              link_clk,
    output logic              link_clk_oe,
    output logic              link_dout,
    output logic              link_dout_oe,
    input  logic              link_din
);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(WORD_W - 1);
    localparam logic [XC_W-1:0]  XC_LAST = XC_W'(XTRA_CLKS - 1);

    link_state_e        state_q;
    link_req_t          req_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   bits_left_q;
    logic [XC_W-1:0]    xtra_left_q;
    logic               rd_tail_q;
    logic [WORD_W-1:0]  cap_q;

    logic               tick;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;
    logic [WORD_W-1:0]  picked;

    sreg_half_timer #(.HALF_CYC(HALF_CYC)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    sreg_frame_build frame_i (
        .req   (req_q),
        .frame (frame),
        .nbits (nbits)
    );

    sreg_word_pick pick_i (
        .tbl  (req_q.tbl),
        .odd  (req_q.addr[0]),
        .raw  (cap_q),
        .word (picked)
    );

    assign busy = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            req_q       <= '0;
            shreg_q     <= '0;
            bits_left_q <= '0;
            xtra_left_q <= '0;
            rd_tail_q   <= 1'b0;
            cap_q       <= '0;
            done        <= 1'b0;
            rdata       <= '0;
        end else begin
            done <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (req_valid) begin
                    req_q     <= '{write: req_write, tbl: req_table,
                                   addr: req_addr, wdata: req_wdata};
                    rd_tail_q <= 1'b0;
                    state_q   <= ST_ENA;
                end
            end else if (tick) begin
                case (state_q)
                    ST_ENA: begin
                        shreg_q     <= frame;
                        bits_left_q <= nbits - 1'b1;
                        state_q     <= req_q.write ? ST_CSUP : ST_CMD_LO;
                    end
                    ST_CSUP:    state_q <= ST_CMD_LO;
                    ST_CMD_LO:  state_q <= ST_CMD_HI;
                    ST_CMD_HI: begin
                        shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                        if (bits_left_q == '0) begin
                            state_q <= ST_CMD_END;
                        end else begin
                            bits_left_q <= bits_left_q - 1'b1;
                            state_q     <= ST_CMD_LO;
                        end
                    end
                    ST_CMD_END: state_q <= ST_TURN;
                    ST_TURN: begin
                        xtra_left_q <= XC_LAST;
                        state_q     <= ST_XTR_HI;
                    end
                    ST_XTR_HI:  state_q <= ST_XTR_LO;
                    ST_XTR_LO: begin
                        if (xtra_left_q != '0) begin
                            xtra_left_q <= xtra_left_q - 1'b1;
                            state_q     <= ST_XTR_HI;
                        end else if (!req_q.write && !rd_tail_q) begin
                            bits_left_q <= RD_LAST;
                            state_q     <= ST_RD_LO;
                        end else begin
                            done    <= 1'b1;
                            if (!req_q.write) begin
                                rdata <= picked;
                            end
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_RD_LO: begin
                        cap_q   <= {cap_q[WORD_W-2:0], link_din};
                        state_q <= ST_RD_HI;
                    end
                    ST_RD_HI: begin
                        if (bits_left_q == '0) begin
                            state_q <= ST_RD_END;
                        end else begin
                            bits_left_q <= bits_left_q - 1'b1;
                            state_q     <= ST_RD_LO;
                        end
                    end
                    ST_RD_END: begin
                        xtra_left_q <= XC_LAST;
                        rd_tail_q   <= 1'b1;
                        state_q     <= ST_XTR_HI;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    logic in_cmd;
    assign in_cmd = (state_q == ST_CMD_LO) || (state_q == ST_CMD_HI);

    assign link_clk     = (state_q == ST_CMD_HI) || (state_q == ST_XTR_HI) ||
                          (state_q == ST_RD_HI);
    assign link_sel     = req_q.write && (in_cmd || (state_q == ST_CSUP) ||
                                          (state_q == ST_CMD_END));
    assign link_dout    = in_cmd && shreg_q[FRAME_W-1];
    assign link_sel_oe  = busy;
    assign link_clk_oe  = busy;
    assign link_dout_oe = (busy && req_q.write) || (state_q == ST_ENA) ||
                          in_cmd || (state_q == ST_CMD_END);

    // R6: data line holds still across a high clock phase
    a_r6_dout_steady_high: assert property (@(posedge clk) disable iff (rst)
        (link_clk && $past(link_clk)) |-> $stable(link_dout));
    // R2: select stays inactive during a read
    a_r2_read_sel_idle: assert property (@(posedge clk) disable iff (rst)
        (busy && !req_q.write) |-> !link_sel);
    // R3: master does not drive while the device answers
    a_r3_rx_released: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_RD_LO) || (state_q == ST_RD_HI)) |-> !link_dout_oe);
    // R7: exchange opens with all lines driven low
    a_r7_open_low: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!link_clk && !link_sel && !link_dout && link_dout_oe));
    // R7: select falls only with the clock low
    a_r7_sel_drop_clk_low: assert property (@(posedge clk) disable iff (rst)
        $fell(link_sel) |-> !link_clk);
    // R9: completion is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: done coincides with busy falling
    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
    // R8: a running request is never replaced
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(req_q));
endmodule

// File: tb/sreg_link_master_tb_top.sv
`timescale 1ns/1ps
module sreg_link_master_tb_top;
    localparam int HALF = 4;
    localparam int NV   = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_table = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done;
    logic [31:0] rdata;
    logic        link_sel, link_sel_oe, link_clk, link_clk_oe, link_dout, link_dout_oe;
    logic        link_din;

    always #2.5 clk = ~clk;

    sreg_link_master #(.HALF_CYC(HALF)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_table(req_table), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata),
        .link_sel(link_sel), .link_sel_oe(link_sel_oe), .link_clk(link_clk),
        .link_clk_oe(link_clk_oe), .link_dout(link_dout), .link_dout_oe(link_dout_oe),
        .link_din(link_din)
    );

    // ---------------- behavioural device model ----------------
    logic [15:0] dev_regs [0:127];
    logic [45:0] rsh;
    logic [26:0] wsh;
    logic [31:0] rword;
    logic        p_clk, p_sel, p_oe, p_dout, saw_sel;
    int          edges, wbits, run_len, last_edges, last_wbits, n_wr;
    int          width_err, chg_err, bus_err, order_err, frame_err;

    function automatic logic [31:0] ctr_val(logic [6:0] a);
        return {8'hEC, {1'b0, a}, ~{1'b0, a}, 8'h5A};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) dev_regs[i] <= {i[7:0], ~i[7:0]};
            rsh <= '0; wsh <= '0; rword <= '0; link_din <= 1'b0;
            p_clk <= 1'b0; p_sel <= 1'b0; p_oe <= 1'b0; p_dout <= 1'b0; saw_sel <= 1'b0;
            edges <= 0; wbits <= 0; run_len <= 0; last_edges <= 0; last_wbits <= 0;
            n_wr <= 0; width_err <= 0; chg_err <= 0; bus_err <= 0;
            order_err <= 0; frame_err <= 0;
        end else begin
            p_clk <= link_clk; p_sel <= link_sel; p_oe <= link_clk_oe; p_dout <= link_dout;
            if (link_clk != p_clk) begin
                if (link_clk_oe && run_len < HALF) width_err <= width_err + 1;
                run_len <= 1;
            end else begin
                run_len <= run_len + 1;
            end
            if (link_clk && p_clk && link_dout_oe && (link_dout != p_dout))
                chg_err <= chg_err + 1;
            if (link_clk && !p_clk) begin
                edges <= edges + 1;
                if (link_sel) begin
                    wsh   <= {wsh[25:0], link_dout};
                    wbits <= wbits + 1;
                end else if (!saw_sel && edges < 46) begin
                    rsh <= {rsh[44:0], link_dout};
                end
                if (!saw_sel && edges >= 46 && link_dout_oe) bus_err <= bus_err + 1;
                if (!saw_sel && edges < 46 && !link_dout_oe) bus_err <= bus_err + 1;
                if (!saw_sel && edges == 47) begin
                    logic [31:0] w;
                    logic [6:0]  a;
                    a = rsh[6:0];
                    if (rsh[45:14] != 32'hFFFF_FFFF || rsh[13:10] != 4'b0110 || rsh[8:7] != 2'b00)
                        frame_err <= frame_err + 1;
                    w = rsh[9] ? ctr_val(a) : {dev_regs[{a[6:1], 1'b1}], dev_regs[{a[6:1], 1'b0}]};
                    rword    <= w;
                    link_din <= w[31];
                end else if (!saw_sel && edges >= 48 && edges < 79) begin
                    link_din <= rword[78 - edges];
                end else begin
                    link_din <= 1'b0;
                end
            end
            if (link_sel) saw_sel <= 1'b1;
            if (p_sel && !link_sel) begin
                if (link_clk) order_err <= order_err + 1;
                if (wbits != 27 || wsh[26:24] != 3'b101) begin
                    frame_err <= frame_err + 1;
                end else begin
                    dev_regs[wsh[22:16]] <= wsh[15:0];
                    n_wr <= n_wr + 1;
                end
            end
            if (p_oe && !link_clk_oe) begin
                last_edges <= edges;
                last_wbits <= wbits;
                edges <= 0; wbits <= 0; saw_sel <= 1'b0;
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_err = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {write, table, addr, wdata, expected}
    localparam logic [57:0] VECS [0:NV-1] = '{
        {1'b0, 1'b0, 8'h04, 16'h0000, 32'h0000_04FB},
        {1'b0, 1'b0, 8'h05, 16'h0000, 32'h0000_05FA},
        {1'b1, 1'b0, 8'h05, 16'hBEEF, 32'h0000_0000},
        {1'b0, 1'b0, 8'h05, 16'h0000, 32'h0000_BEEF},
        {1'b0, 1'b0, 8'h04, 16'h0000, 32'h0000_04FB},
        {1'b0, 1'b1, 8'h10, 16'h0000, 32'hEC10_EF5A},
        {1'b1, 1'b0, 8'h7F, 16'h1234, 32'h0000_0000},
        {1'b0, 1'b0, 8'h7F, 16'h0000, 32'h0000_1234},
        {1'b0, 1'b1, 8'h7F, 16'h0000, 32'hEC7F_805A},
        {1'b1, 1'b0, 8'h00, 16'hFFFF, 32'h0000_0000},
        {1'b0, 1'b0, 8'h00, 16'h0000, 32'h0000_FFFF},
        {1'b0, 1'b0, 8'h01, 16'h0000, 32'h0000_01FE}
    };

    task automatic run_txn(input logic w, input logic t, input logic [7:0] a,
                           input logic [15:0] d, output logic [31:0] rd,
                           output int bcyc, output logic open_ok);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_table = t; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        open_ok = link_sel_oe && link_clk_oe && link_dout_oe &&
                  !link_sel && !link_clk && !link_dout;
        bcyc = 0; rd = 'x;
        for (int i = 0; i < 5000; i++) begin
            if (done) begin
                rd = rdata;
                break;
            end
            if (busy) bcyc++;
            @(negedge clk);
        end
        chk("R9 done seen", {31'b0, done}, 32'd1);
        @(negedge clk);
        chk("R9 done single pulse", {31'b0, done}, 32'd0);
        chk("R7 drivers released", {29'b0, link_sel_oe, link_clk_oe, link_dout_oe}, 32'd0);
    endtask

    initial begin
        logic [31:0] rd;
        int          bc, wr_before;
        logic        open_ok;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy/done", {30'b0, busy, done}, 32'd0);
        chk("R1 enables", {29'b0, link_sel_oe, link_clk_oe, link_dout_oe}, 32'd0);
        chk("R1 rdata", rdata, 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic [57:0] e;
            e = VECS[v];
            run_txn(e[57], e[56], e[55:48], e[47:32], rd, bc, open_ok);
            @(negedge clk);
            chk("R7 opens all low", {31'b0, open_ok}, 32'd1);
            if (e[57]) begin
                chk("R8 write busy length", bc, 62 * HALF);
                chk("R5 write edge count", last_edges, 32'd29);
                chk("R5 write bits under select", last_wbits, 32'd27);
            end else begin
                chk("R8 read busy length", bc, 168 * HALF);
                chk("R3 read edge count", last_edges, 32'd82);
                chk(e[56] ? "R4 counter word" : (e[48] ? "R4 odd upper half" : "R4 even lower half"),
                    rd, e[31:0]);
            end
        end

        // R8: request during an exchange is ignored
        wr_before = n_wr;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_table = 1'b0; req_addr = 8'h22;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h22; req_wdata = 16'h0BAD;
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        rd = 'x;
        for (int i = 0; i < 5000; i++) begin
            if (done) begin
                rd = rdata;
                break;
            end
            @(negedge clk);
        end
        chk("R8 busy request ignored, result", rd, 32'h0000_22DD);
        @(negedge clk);
        chk("R8 no write reached device", n_wr, wr_before);
        run_txn(1'b0, 1'b0, 8'h22, 16'h0, rd, bc, open_ok);
        chk("R8 register unchanged", rd, 32'h0000_22DD);

        // protocol monitors
        chk("R6 phase width", width_err, 0);
        chk("R6 data change with clock high", chg_err, 0);
        chk("R3 data line ownership", bus_err, 0);
        chk("R7 select released with clock low", order_err, 0);
        chk("R2 R5 frame format", frame_err, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule